// File: doc/BRIEF.md
# Mains-Referenced Minute Prescaler

This block turns a squared 50 Hz mains waveform into the timing pulses of a binary wall clock. A fast system clock samples the mains input through a two-flop synchronizer. Each rising mains edge becomes a one-cycle enable that drives a chain of seven enabled counter stages. The stage moduli are 5, 5, 2, 2, 3, 5, 2, giving an overall ratio of 3000. Because the divide-by-2 stages come after the divide-by-5 stages, the seconds and minute taps are 50% duty square waves rather than narrow pulses.

Downstream minute and hour counters consume a single-cycle `minute_tick` strobe. A time-setting switch, once debounced, changes which tap that strobe comes from. While the switch is held, the tick follows the rising edge of the 1 Hz square wave, so the clock advances one minute per second. A pilot output drives a seconds indicator. A build parameter chooses whether it blinks at 1 Hz or 0.5 Hz.

Top module: `mains_minute_prescaler`

## Requirements
- R1: A synchronous active-low reset clears every divider stage, the synchronizers, the debouncer and the tick register, so all outputs read 0 in the cycle after a clocked reset.
- R2: Each rising edge of `mains_in` advances the chain exactly once, however long the high level lasts. A rising edge that is set up before clock edge E1 shows on the outputs after edge E3.
- R3: After n mains rising edges since reset, `sec_sq` equals floor(n/25) mod 2, which is a 1 Hz square wave with 50% duty.
- R4: With `PILOT_SLOW`=0, `pilot` equals `sec_sq`. With `PILOT_SLOW`=1, `pilot` equals floor(n/50) mod 2.
- R5: `minute_sq` equals floor(n/1500) mod 2, so the total division ratio is 3000.
- R6: With `set_active`=0, `minute_tick` is high for exactly one cycle, once for each rising edge of `minute_sq`, that is at n ≡ 1500 (mod 3000).
- R7: With `set_active`=1, `minute_tick` pulses for one cycle at each rising edge of `sec_sq` (n ≡ 25 mod 50) and never at any other count.
- R8: `set_active` takes the synchronized `set_raw` level only after that level has differed from it for `DEBOUNCE_CYCLES` consecutive clocks. A step of `set_raw` driven before edge E1 appears after edge E(`DEBOUNCE_CYCLES`+2). Shorter glitches leave `set_active` unchanged.
- R9: The set switch does not disturb the divider chain. `sec_sq`, `pilot` and `minute_sq` keep following the edge count n while the switch is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mains_in | input | 1 | Squared 50 Hz mains reference, asynchronous |
| set_raw | input | 1 | Raw time-setting switch, asynchronous and bouncing |
| minute_tick | output | 1 | One-cycle strobe for the downstream minute counter |
| minute_sq | output | 1 | One-minute-period square wave |
| sec_sq | output | 1 | 1 Hz square wave |
| pilot | output | 1 | Seconds indicator drive, 1 Hz or 0.5 Hz |
| set_active | output | 1 | Debounced set-switch state selecting the fast tick source |

## Verification
A mains rising edge crosses two synchronizer flops before it becomes an enable. The stage counts and the registered tick therefore all change on the third clock edge after the input step. The bench drives each mains edge on a falling clock edge and samples every output three falling edges later. It then samples `minute_tick` once more one cycle after that, to confirm the strobe has dropped. The debounced switch state is due `DEBOUNCE_CYCLES`+2 edges after a step, so the bench checks that it is still low one cycle before that point and high at it. Mains is held idle during these switch checks so the two timings cannot mix.

// File: rtl/mpre_pkg.sv
// Package: shared constants of the mains minute prescaler.
// Assumes a fixed seven-stage chain; stage moduli never exceed 2**CNT_W.
package mpre_pkg;
    localparam int NUM_STAGES = 7;
    localparam int CNT_W      = 3;
    // Tap positions: the divide-by-2 stages whose count is a square wave.
    localparam int STG_SEC    = 2;
    localparam int STG_HALF   = 3;
    localparam int STG_MIN    = 6;

    // Modulus of each stage: /5 /5 /2 /2 /3 /5 /2 (order sets the duty cycles).
    function automatic int stage_mod(input int idx);
        case (idx)
            0, 1, 5: return 5;
            4:       return 3;
            default: return 2;
        endcase
    endfunction
endpackage

// File: rtl/mpre_sync_edge.sv
// Two-flop synchronizer followed by a rising-edge detector.
// Assumes the input is slow relative to clk; rise is a one-cycle pulse.
module mpre_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    // Capture the asynchronous level and remember the previous synced value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;

    // R2
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/mpre_div_stage.sv
// One enabled modulo-MOD counter of the divide chain.
// Assumes MOD <= 2**W; wrap is asserted in the enabled cycle that returns to 0.
module mpre_div_stage #(
    parameter int MOD = 5,
    parameter int W   = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic [W-1:0] count,
    output logic         wrap
);
    localparam logic [W-1:0] LAST = W'(MOD - 1);

    assign wrap = en && (count == LAST);

    // Advance on enable, return to zero after the last state.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (wrap) count <= '0;
        else if (en)  count <= count + 1'b1;
    end

    // R5
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST);
    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(count));
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (count == '0));
endmodule

// File: rtl/mpre_debounce.sv
// Debouncer for the set switch: synchronizes, then requires CYCLES
// consecutive differing samples before the output follows.
// Assumes CYCLES >= 2.
module mpre_debounce #(
    parameter int CYCLES = 2_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic state
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic meta_q, sync_q;
    logic [CW-1:0] run_q;

    // Bring the switch level into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
        end
    end

    // Count consecutive disagreeing samples; flip when the run is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            state <= 1'b0;
        end else if (sync_q == state) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            run_q <= '0;
            state <= sync_q;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // R8
    rise_needs_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state) |-> $past(sync_q));
    // R8
    fall_needs_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state) |-> !$past(sync_q));
endmodule

// File: rtl/mains_minute_prescaler.sv
// Top: divides synchronized 50 Hz mains edges by 3000 through a chain of
// enabled counters, produces seconds/minute square waves, a pilot drive and
// a one-cycle minute strobe whose source a debounced set switch selects.
// Assumes clk is much faster than mains; PILOT_SLOW picks the 0.5 Hz pilot.
module mains_minute_prescaler #(
    parameter int DEBOUNCE_CYCLES = 2_500_000,
    parameter bit PILOT_SLOW      = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mains_in,
    input  logic set_raw,
    output logic minute_tick,
    output logic minute_sq,
    output logic sec_sq,
    output logic pilot,
    output logic set_active
);
    import mpre_pkg::*;

    logic                  mains_rise;
    logic [NUM_STAGES:0]   stage_en;
    logic [CNT_W-1:0]      stage_cnt [NUM_STAGES];
    logic                  sec_rise, min_rise, tick_q;

    mpre_sync_edge u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (mains_in),
        .rise     (mains_rise)
    );

    mpre_debounce #(.CYCLES(DEBOUNCE_CYCLES)) u_db (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (set_raw),
        .state (set_active)
    );

    assign stage_en[0] = mains_rise;

    // Divider chain: each stage is enabled by the wrap of the one before.
    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        mpre_div_stage #(.MOD(stage_mod(i)), .W(CNT_W)) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (stage_en[i]),
            .count (stage_cnt[i]),
            .wrap  (stage_en[i+1])
        );
    end

    assign sec_sq    = stage_cnt[STG_SEC][0];
    assign minute_sq = stage_cnt[STG_MIN][0];

    // Pilot source chosen at build time.
    if (PILOT_SLOW) begin : g_pilot_slow
        assign pilot = stage_cnt[STG_HALF][0];
    end else begin : g_pilot_fast
        assign pilot = stage_cnt[STG_SEC][0];
    end

    // A divide-by-2 tap rises when it is enabled while at zero.
    assign sec_rise = stage_en[STG_SEC] && !stage_cnt[STG_SEC][0];
    assign min_rise = stage_en[STG_MIN] && !stage_cnt[STG_MIN][0];

    // Register the strobe from the tap the set switch selects.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= set_active ? sec_rise : min_rise;
    end

    assign minute_tick = tick_q;

    // R6
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        minute_tick |=> !minute_tick);
    // R6
    tick_normal_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (minute_tick && !$past(set_active)) |-> (minute_sq && !$past(minute_sq)));
    // R7
    tick_fast_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (minute_tick && $past(set_active)) |-> (sec_sq && !$past(sec_sq)));
    // R1
    tick_reset_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> !minute_tick);
endmodule

// File: tb/mains_minute_prescaler_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module mains_minute_prescaler_tb_top;
    localparam int DB = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mains_in = 1'b0;
    logic set_raw = 1'b0;
    logic minute_tick, minute_sq, sec_sq, pilot, set_active;
    logic tick_s, min_s, sec_s, pil_s, act_s;

    int tests_run = 0;
    int tests_failed = 0;
    int n_edges = 0;
    bit exp_set = 1'b0;
    int ticks_seen = 0;

    always #4 clk = ~clk;

    mains_minute_prescaler #(.DEBOUNCE_CYCLES(DB), .PILOT_SLOW(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .mains_in(mains_in), .set_raw(set_raw),
        .minute_tick(minute_tick), .minute_sq(minute_sq), .sec_sq(sec_sq),
        .pilot(pilot), .set_active(set_active)
    );

    mains_minute_prescaler #(.DEBOUNCE_CYCLES(DB), .PILOT_SLOW(1'b1)) dut_slow_i (
        .clk(clk), .rst_n(rst_n), .mains_in(mains_in), .set_raw(set_raw),
        .minute_tick(tick_s), .minute_sq(min_s), .sec_sq(sec_s),
        .pilot(pil_s), .set_active(act_s)
    );

    task automatic check(input string req, input logic act, input logic exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s at edge %0d: actual %b expected %b", req, n_edges, act, exp);
        end
    endtask

    // One mains pulse; outputs checked three falling edges after the step.
    task automatic mains_pulse_check();
        logic et;
        mains_in = 1'b1;
        n_edges++;
        repeat (3) @(negedge clk);
        et = exp_set ? (n_edges % 50 == 25) : (n_edges % 3000 == 1500);
        check("R3 sec_sq", sec_sq, 1'((n_edges / 25) % 2));
        check("R4 pilot fast", pilot, 1'((n_edges / 25) % 2));
        check("R4 pilot slow", pil_s, 1'((n_edges / 50) % 2));
        check("R5 minute_sq", minute_sq, 1'((n_edges / 1500) % 2));
        check(exp_set ? "R7 fast tick" : "R6 tick", minute_tick, et);
        if (minute_tick) ticks_seen++;
        mains_in = 1'b0;
        @(negedge clk);
        check("R6 tick one cycle", minute_tick, 1'b0);
        repeat (3) @(negedge clk);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 tick", minute_tick, 1'b0);
        check("R1 minute_sq", minute_sq, 1'b0);
        check("R1 sec_sq", sec_sq, 1'b0);
        check("R1 pilot", pilot, 1'b0);
        check("R1 set_active", set_active, 1'b0);
        rst_n = 1'b1;
        n_edges = 0;
        @(negedge clk);
    endtask

    // R2: a long high level counts once.
    task automatic test_long_high();
        mains_in = 1'b1;
        n_edges++;
        repeat (30) @(negedge clk);
        mains_in = 1'b0;
        repeat (4) @(negedge clk);
        repeat (23) mains_pulse_check();
        check("R2 one count per edge (24)", sec_sq, 1'b0);
        mains_pulse_check();
        check("R2 one count per edge (25)", sec_sq, 1'b1);
    endtask

    // R5/R6: run through two minute-square rises.
    task automatic test_normal(input int upto);
        ticks_seen = 0;
        while (n_edges < upto) mains_pulse_check();
        tests_run++;
        if (ticks_seen != 2) begin
            tests_failed++;
            $display("FAIL R6 tick count: actual %0d expected %0d", ticks_seen, 2);
        end
    endtask

    // R8: a glitch shorter than the window is ignored.
    task automatic test_glitch();
        set_raw = 1'b1;
        repeat (DB / 2) @(negedge clk);
        set_raw = 1'b0;
        repeat (DB + 10) @(negedge clk);
        check("R8 glitch ignored", set_active, 1'b0);
    endtask

    // R8: exact debounce latency for a step.
    task automatic test_step(input logic lvl);
        set_raw = lvl;
        repeat (DB + 1) @(negedge clk);
        check("R8 not yet", set_active, ~lvl);
        @(negedge clk);
        check("R8 taken", set_active, lvl);
        exp_set = lvl;
    endtask

    // R7/R9: fast set ticks once per second, chain undisturbed.
    task automatic test_fast(input int pulses);
        ticks_seen = 0;
        repeat (pulses) mains_pulse_check();
        tests_run++;
        if (ticks_seen != pulses / 50) begin
            tests_failed++;
            $display("FAIL R7 fast tick count: actual %0d expected %0d", ticks_seen, pulses / 50);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        test_reset();
        test_long_high();
        test_normal(4600);
        test_glitch();
        test_step(1'b1);
        test_fast(150);
        test_step(1'b0);
        repeat (100) mains_pulse_check();
        test_reset();
        repeat (60) mains_pulse_check();
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule